// File: doc/BRIEF.md
# Flash Write Command Qualifier

This block sits in front of a flash command register. It decides whether a bus cycle on the asynchronous control pins is a real write. The pins are chip-enable, output-enable and write-enable, all active low. Each pin is brought into the local clock domain. The block then measures how long write-enable stays low in the write condition, with chip-enable low and output-enable high. A short pulse, shorter than a set number of samples, is rejected as noise. On the rising edge of write-enable, a qualified write raises a one-clock strobe for the command register.

Two further guards stand in the way of that strobe. The first is a digital lockout flag, which stands for a low supply rail. While the flag is high, every write is ignored. When the flag rises, a one-clock return-to-read pulse is sent. The second guard applies after reset, which also raises the return-to-read pulse once. After reset, and again after any lockout, no rising edge counts until write-enable has been seen high. Because of this, a part that powers up with its write pins already active does not take the first edge as a command.

Top module: `flash_wr_qualifier`

## Requirements
- R1: A write-enable low period, with chip-enable low and output-enable high, that lasts at least MIN_LOW_SAMPLES (default 4) clock samples gives exactly one wr_strobe_o pulse when write-enable rises.
- R2: If output-enable is low during the low period, no strobe is produced.
- R3: If chip-enable is high during the low period, no strobe is produced.
- R4: A low period of MIN_LOW_SAMPLES-1 samples or fewer gives no strobe. Exactly MIN_LOW_SAMPLES samples is enough.
- R5: wr_strobe_o lasts one clock. It goes high on the third rising clock edge after the write-enable pin rises (SYNC_STAGES=2 plus one output register).
- R6: In the first clock after reset is released, read_reset_o is high for exactly one clock.
- R7: After reset, no rising edge is accepted until write-enable has been sampled high. If the pins are held in the write condition through reset, the first rising edge gives no strobe. A later valid pulse does.
- R8: While lockout_i is high, no strobe is produced, whatever the pins do.
- R9: A rising edge on lockout_i gives one read_reset_o pulse on the next clock. No further pulse follows while the flag stays high.
- R10: After lockout_i falls, write-enable must again be sampled high before a rising edge is accepted. A low period that began during lockout gives no strobe.
- R11: If lockout_i is high in the same cycle that a qualified write-enable rise is decided, the strobe is suppressed and the return-to-read pulse is still issued.
- R12: While rst_n is low, wr_strobe_o and read_reset_o are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip-enable pin, active low, asynchronous |
| oe_n | input | 1 | Output-enable pin, active low, asynchronous |
| we_n | input | 1 | Write-enable pin, active low, asynchronous |
| lockout_i | input | 1 | Low-supply lockout flag, synchronous to clk |
| wr_strobe_o | output | 1 | One-clock qualified write strobe |
| read_reset_o | output | 1 | One-clock return-to-read-mode pulse |

## Verification
A write-enable rise that has fully qualified and a rising lockout flag can meet in the same decision cycle. The strobe path and the return-to-read path then act at once. The bench raises write-enable after a long valid low period and sets lockout two clocks later, so that the flag is present in the very cycle the rise is judged. It then requires that the strobe stays low while read_reset_o pulses on that same sample.

// File: rtl/fwq_pkg.sv
// Shared types for the flash write command qualifier.
// Assumes: pins are active low and grouped as {ce, oe, we}.
package fwq_pkg;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } ctl_pins_t;

    localparam int CTL_W = $bits(ctl_pins_t);

    // Pessimistic reset image: chip selected, outputs off, write active.
    // A real write-enable high has to travel the synchronizer before it is seen.
    localparam ctl_pins_t CTL_RESET_IMAGE = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0};

endpackage

// File: rtl/fwq_pin_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes: each bit is independent; the reset value is given by RST_VAL.
module fwq_pin_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage captures the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= din;
            end
        end else begin : g_next
            // Later stages shift the value along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/fwq_arm_ctl.sv
// Arming flag: rising write-enable edges are only eligible once
// write-enable has been observed high outside lockout.
// Assumes: we_s is already synchronized; lockout_i is synchronous.
module fwq_arm_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic we_s,
    input  logic lockout_i,
    output logic armed
);

    // Clear on reset or lockout, set when write-enable is seen high.
    always_ff @(posedge clk) begin
        if (!rst_n)        armed <= 1'b0;
        else if (lockout_i) armed <= 1'b0;
        else if (we_s)      armed <= 1'b1;
    end

    AST_ARM_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(we_s)); // R7

    AST_ARM_DROPS_IN_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        lockout_i |=> !armed); // R10

endmodule

// File: rtl/fwq_low_filter.sv
// Measures the write-condition low period of write-enable and produces
// the registered strobe on a qualified rising edge.
// Assumes: inputs are synchronized; accept_en already folds arm and lockout.
module fwq_low_filter #(
    parameter int MIN_LOW_SAMPLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_s,
    input  logic oe_s,
    input  logic we_s,
    input  logic clear,
    input  logic accept_en,
    output logic strobe_o
);

    localparam int CW = $clog2(MIN_LOW_SAMPLES + 1);
    localparam logic [CW-1:0] FULL = CW'(MIN_LOW_SAMPLES);

    logic [CW-1:0] low_cnt;
    logic          we_q;
    logic          in_write;
    logic          low_full;
    logic          we_rise;

    assign in_write = !ce_s && oe_s && !we_s;
    assign low_full = (low_cnt == FULL);
    assign we_rise  = we_s && !we_q;

    // Saturating count of consecutive samples in the write condition.
    always_ff @(posedge clk) begin
        if (!rst_n)                low_cnt <= '0;
        else if (clear || !in_write) low_cnt <= '0;
        else if (!low_full)          low_cnt <= low_cnt + 1'b1;
    end

    // Delayed write-enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) we_q <= 1'b0;
        else        we_q <= we_s;
    end

    // Registered strobe on a rising edge that ends a long enough low period.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_o <= 1'b0;
        else        strobe_o <= we_rise && low_full && accept_en;
    end

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= FULL); // R4

    AST_STROBE_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> $past(low_cnt) == FULL); // R4

endmodule

// File: rtl/fwq_supply_guard.sv
// Return-to-read pulse source: once after reset, and once per rising
// edge of the lockout flag.
// Assumes: lockout_i is synchronous to clk.
module fwq_supply_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic lockout_i,
    output logic read_reset_o
);

    logic boot_q;
    logic lock_q;

    // One-shot marker for the first cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) boot_q <= 1'b1;
        else        boot_q <= 1'b0;
    end

    // Previous lockout level; reset high so a held flag gives no extra edge.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b1;
        else        lock_q <= lockout_i;
    end

    // Registered return-to-read pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) read_reset_o <= 1'b0;
        else        read_reset_o <= boot_q || (lockout_i && !lock_q);
    end

    AST_READ_ON_LOCK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lockout_i) |=> read_reset_o); // R9

    AST_NO_REPEAT_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lockout_i && $past(lockout_i) && !boot_q) |=> !read_reset_o); // R9

endmodule

// File: rtl/flash_wr_qualifier.sv
// Top: turns asynchronous flash control pins into a qualified write strobe,
// with glitch rejection, lockout and a post-reset arming guard.
// Assumes: one clock domain; lockout_i arrives already synchronous.
module flash_wr_qualifier #(
    parameter int SYNC_STAGES     = 2,
    parameter int MIN_LOW_SAMPLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic lockout_i,
    output logic wr_strobe_o,
    output logic read_reset_o
);

    import fwq_pkg::*;

    ctl_pins_t pins_raw;
    ctl_pins_t pins_s;
    logic      armed;
    logic      accept_en;

    assign pins_raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n};

    fwq_pin_sync #(
        .W      (CTL_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(CTL_RESET_IMAGE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    fwq_arm_ctl u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_s     (pins_s.we_n),
        .lockout_i(lockout_i),
        .armed    (armed)
    );

    // Lockout overrides everything, including a rise judged in this cycle.
    assign accept_en = armed && !lockout_i;

    fwq_low_filter #(
        .MIN_LOW_SAMPLES(MIN_LOW_SAMPLES)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_s     (pins_s.ce_n),
        .oe_s     (pins_s.oe_n),
        .we_s     (pins_s.we_n),
        .clear    (lockout_i),
        .accept_en(accept_en),
        .strobe_o (wr_strobe_o)
    );

    fwq_supply_guard u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .lockout_i   (lockout_i),
        .read_reset_o(read_reset_o)
    );

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe_o |=> !wr_strobe_o); // R5

    AST_NO_STROBE_IN_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe_o |-> !$past(lockout_i)); // R8 R11

endmodule

// File: tb/flash_wr_qualifier_tb_top.sv
module flash_wr_qualifier_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1;
    logic oe_n = 1'b1;
    logic we_n = 1'b1;
    logic lockout_i = 1'b0;
    logic wr_strobe_o;
    logic read_reset_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flash_wr_qualifier #(.SYNC_STAGES(2), .MIN_LOW_SAMPLES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .lockout_i(lockout_i), .wr_strobe_o(wr_strobe_o), .read_reset_o(read_reset_o)
    );

    typedef struct packed {
        logic ce;
        logic oe;
        int   low;
        logic lock;
        int   exp;
        int   req;
    } vec_t;

    // ce, oe, low samples, lockout, expected strobes, requirement number
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 6,  1'b0, 1, 1},  // R1
        '{1'b0, 1'b1, 4,  1'b0, 1, 4},  // R4 exact threshold
        '{1'b0, 1'b1, 3,  1'b0, 0, 4},  // R4 one short
        '{1'b0, 1'b1, 1,  1'b0, 0, 4},  // R4 single-sample glitch
        '{1'b0, 1'b0, 6,  1'b0, 0, 2},  // R2
        '{1'b1, 1'b1, 6,  1'b0, 0, 3},  // R3
        '{1'b1, 1'b0, 6,  1'b0, 0, 3},  // R3
        '{1'b0, 1'b1, 6,  1'b1, 0, 8},  // R8
        '{1'b0, 1'b1, 10, 1'b0, 1, 1}   // R1 long pulse
    };

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(int actual, int expected, string tag);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic idle(int n);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        tick(n);
    endtask

    // Low phase of 'low' cycles, then rise; count strobes afterwards.
    task automatic pulse(logic ce, logic oe, int low, logic lock, output int strobes);
        lockout_i = lock;
        idle(4);
        ce_n = ce; oe_n = oe; we_n = 1'b0;
        tick(low);
        we_n = 1'b1;
        strobes = 0;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            if (wr_strobe_o) strobes++;
        end
        lockout_i = 1'b0;
        idle(3);
    endtask

    initial begin
        int s;
        int rr;
        // R12: outputs low during reset
        tick(3);
        check(wr_strobe_o, 0, "R12 strobe in reset");
        check(read_reset_o, 0, "R12 read pulse in reset");
        rst_n = 1'b1;
        tick(1);
        check(read_reset_o, 1, "R6 read pulse after reset");
        tick(1);
        check(read_reset_o, 0, "R6 read pulse width");
        idle(4);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            pulse(VECS[v].ce, VECS[v].oe, VECS[v].low, VECS[v].lock, s);
            check(s, VECS[v].exp, $sformatf("R%0d vector %0d strobes", VECS[v].req, v));
        end

        // R5: exact latency and width
        idle(4);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
        tick(5);
        we_n = 1'b1;
        tick(1); check(wr_strobe_o, 0, "R5 edge+1");
        tick(1); check(wr_strobe_o, 0, "R5 edge+2");
        tick(1); check(wr_strobe_o, 1, "R5 edge+3");
        tick(1); check(wr_strobe_o, 0, "R5 width");
        idle(3);

        // R9: lockout edge gives one pulse only
        lockout_i = 1'b1;
        tick(1); check(read_reset_o, 1, "R9 pulse on lockout rise");
        rr = 0;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            if (read_reset_o) rr++;
        end
        check(rr, 0, "R9 no repeat while held");

        // R10: low period begun in lockout, released while low
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
        tick(3);
        lockout_i = 1'b0;
        tick(8);
        we_n = 1'b1;
        s = 0;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            if (wr_strobe_o) s++;
        end
        check(s, 0, "R10 no strobe without re-arm");
        pulse(1'b0, 1'b1, 6, 1'b0, s);
        check(s, 1, "R10 strobe after re-arm");

        // R11: lockout rises in the decision cycle of a qualified rise
        idle(4);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
        tick(6);
        we_n = 1'b1;
        tick(2);
        lockout_i = 1'b1;
        tick(1);
        check(wr_strobe_o, 0, "R11 strobe suppressed");
        check(read_reset_o, 1, "R11 read pulse same sample");
        s = 0;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            if (wr_strobe_o) s++;
        end
        check(s, 0, "R11 no late strobe");
        lockout_i = 1'b0;
        idle(4);

        // R7: power-up with write condition held through reset
        rst_n = 1'b0;
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        check(read_reset_o, 1, "R6 read pulse after second reset");
        tick(8);
        we_n = 1'b1;
        s = 0;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            if (wr_strobe_o) s++;
        end
        check(s, 0, "R7 first edge after power-up rejected");
        pulse(1'b0, 1'b1, 5, 1'b0, s);
        check(s, 1, "R7 later pulse accepted");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule